// File: doc/BRIEF.md
# Codec FIFO Status and Interrupt Unit

This unit watches the two word FIFOs that sit around a voice converter. The input FIFO is filled by the host and drained by the converter. The output FIFO is filled by the converter and drained by the host. The unit counts occupancy on both sides from push and pop strobes. It keeps sticky event flags for approaching limits, for converter errors and for PCM holding register service. From those flags it derives one interrupt line and one DMA request per direction.

Software reads a single 16-bit status word. The read strobe clears every flag, but an event that lands in the same cycle as the read survives it. The unit holds no FIFO storage and no converter datapath. It only sees strobes and the two PCM holding register levels.

Top module: `codec_stat_unit`

## Requirements
- R1: After reset the status word reads 0x0800 (no flags, eight free input slots, zero output words) and `irq` is 0. In any cycle after `en` was low, the status word, `irq` and both DMA requests read 0, and both occupancy counts restart from empty.
- R2: Status bits [11:8] hold the number of free input slots (DEPTH minus the stored words). Bits [15:12] hold the number of stored output words. Bits [7:5] read 0. A push and a pop in the same cycle leave the count unchanged.
- R3: Flag bit 0 (input low) sets when an input pop drops the stored count from THRESH+1 to THRESH. Filling through that level does not set it.
- R4: Flag bit 1 (output high) sets when an output push raises the stored count from DEPTH-THRESH-1 to DEPTH-THRESH.
- R5: Flag bit 3 (underrun) sets when the converter pops the input FIFO while it holds no word. The count stays 0.
- R6: Flag bit 4 (overrun) sets when the converter pushes the output FIFO while it holds DEPTH words. The count stays at DEPTH.
- R7: Flag bit 2 (PCM service) sets in every enabled cycle in which `pcm_out_full` or `pcm_in_empty` is high.
- R8: Flags are sticky. A cycle with `stat_rd` high clears every flag, unless that flag's set event occurs in the same cycle, in which case it stays 1.
- R9: `irq` is 1 one cycle after the flags and enables call for it: any of bits 0–2 with `ie_data` high, or bit 3 or 4 with `ie_err` high.
- R10: `dma_in_req` follows flag bit 0 gated by `dma_in_en`. `dma_out_req` follows flag bit 1 gated by `dma_out_en`. Both are aligned with the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable; low clears flags and counts |
| in_push | input | 1 | Host writes one word to the input FIFO |
| in_pop | input | 1 | Converter reads one word from the input FIFO |
| out_push | input | 1 | Converter writes one word to the output FIFO |
| out_pop | input | 1 | Host reads one word from the output FIFO |
| pcm_out_full | input | 1 | PCM output holding register is full |
| pcm_in_empty | input | 1 | PCM input holding register is empty |
| stat_rd | input | 1 | Status word is being read this cycle |
| ie_data | input | 1 | Interrupt enable for threshold and PCM flags |
| ie_err | input | 1 | Interrupt enable for underrun and overrun flags |
| dma_in_en | input | 1 | DMA enable for the input direction |
| dma_out_en | input | 1 | DMA enable for the output direction |
| status | output | 16 | Registered status word |
| irq | output | 1 | Registered interrupt request |
| dma_in_req | output | 1 | Registered input DMA request |
| dma_out_req | output | 1 | Registered output DMA request |

## Verification
The bench builds the unit with DEPTH 8 and THRESH 3. With these values a full drain or fill takes only a few strobes, so both thresholds, both error limits and the count boundaries 0 and DEPTH are all reached within a short vector table. The directed part then covers enable gating, and it checks each interrupt and DMA enable on its own. It also holds a PCM level across a read to show that a same-cycle event outlives the clear.

// File: rtl/codec_stat_pkg.sv
package codec_stat_pkg;
  localparam int FLAG_W   = 5;
  localparam int F_LOW    = 0;
  localparam int F_HIGH   = 1;
  localparam int F_PCM    = 2;
  localparam int F_UNDER  = 3;
  localparam int F_OVER   = 4;
  localparam int STAT_W   = 16;
  localparam int SLOT_LSB = 8;
endpackage

// File: rtl/codec_occ_track.sv
module codec_occ_track #(
  parameter int DEPTH  = 8,
  parameter int THRESH = 3,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic          dec_empty,
  output logic          inc_full,
  output logic          fall_hit,
  output logic          rise_hit
);
  localparam logic [CW-1:0] FULL   = CW'(DEPTH);
  localparam logic [CW-1:0] LOWLVL = CW'(THRESH);
  localparam logic [CW-1:0] HILVL  = CW'(DEPTH - THRESH);

  logic inc_ok, dec_ok;

  always_comb begin
    dec_empty = dec && (cnt_q == '0);
    inc_full  = inc && (cnt_q == FULL);
    inc_ok    = inc && !inc_full;
    dec_ok    = dec && !dec_empty;
    cnt_nxt   = cnt_q;
    if (clr)
      cnt_nxt = '0;
    else if (inc_ok && !dec_ok)
      cnt_nxt = cnt_q + 1'b1;
    else if (dec_ok && !inc_ok)
      cnt_nxt = cnt_q - 1'b1;
    fall_hit  = !clr && (cnt_q == LOWLVL + 1'b1) && (cnt_nxt == LOWLVL);
    rise_hit  = !clr && (cnt_q == HILVL - 1'b1) && (cnt_nxt == HILVL);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/codec_sticky_flags.sv
module codec_sticky_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         rd,
  input  logic [N-1:0] set,
  output logic [N-1:0] flg_nxt,
  output logic [N-1:0] flg_q
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (!en)       flg_nxt[i] = 1'b0;
      else if (set[i]) flg_nxt[i] = 1'b1;
      else if (rd)   flg_nxt[i] = 1'b0;
      else           flg_nxt[i] = flg_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flg_q <= '0;
    else     flg_q <= flg_nxt;
  end
endmodule

// File: rtl/codec_stat_unit.sv
module codec_stat_unit
  import codec_stat_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int THRESH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              in_push,
  input  logic              in_pop,
  input  logic              out_push,
  input  logic              out_pop,
  input  logic              pcm_out_full,
  input  logic              pcm_in_empty,
  input  logic              stat_rd,
  input  logic              ie_data,
  input  logic              ie_err,
  input  logic              dma_in_en,
  input  logic              dma_out_en,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              dma_in_req,
  output logic              dma_out_req
);
  localparam int CW       = $clog2(DEPTH + 1);
  localparam int OCNT_LSB = SLOT_LSB + CW;
  localparam int PAD_W    = SLOT_LSB - FLAG_W;

  logic [CW-1:0]     icnt_q, icnt_nxt, ocnt_q, ocnt_nxt, islots;
  logic              i_under, i_over_unused, i_fall, i_rise_unused;
  logic              o_under_unused, o_over, o_fall_unused, o_rise;
  logic [FLAG_W-1:0] set_v, flg_nxt, flg_q;
  logic [STAT_W-1:0] stat_nxt;

  codec_occ_track #(.DEPTH(DEPTH), .THRESH(THRESH)) u_in_occ (
    .clk(clk), .rst(rst), .clr(!en), .inc(in_push), .dec(in_pop),
    .cnt_q(icnt_q), .cnt_nxt(icnt_nxt), .dec_empty(i_under),
    .inc_full(i_over_unused), .fall_hit(i_fall), .rise_hit(i_rise_unused)
  );

  codec_occ_track #(.DEPTH(DEPTH), .THRESH(THRESH)) u_out_occ (
    .clk(clk), .rst(rst), .clr(!en), .inc(out_push), .dec(out_pop),
    .cnt_q(ocnt_q), .cnt_nxt(ocnt_nxt), .dec_empty(o_under_unused),
    .inc_full(o_over), .fall_hit(o_fall_unused), .rise_hit(o_rise)
  );

  always_comb begin
    set_v          = '0;
    set_v[F_LOW]   = i_fall;
    set_v[F_HIGH]  = o_rise;
    set_v[F_PCM]   = pcm_out_full || pcm_in_empty;
    set_v[F_UNDER] = i_under;
    set_v[F_OVER]  = o_over;
  end

  codec_sticky_flags #(.N(FLAG_W)) u_flags (
    .clk(clk), .rst(rst), .en(en), .rd(stat_rd), .set(set_v),
    .flg_nxt(flg_nxt), .flg_q(flg_q)
  );

  always_comb begin
    islots   = CW'(DEPTH) - icnt_nxt;
    stat_nxt = '0;
    stat_nxt[FLAG_W-1:0]         = flg_nxt;
    stat_nxt[SLOT_LSB +: CW]     = islots;
    stat_nxt[OCNT_LSB +: CW]     = ocnt_nxt;
    stat_nxt[FLAG_W +: PAD_W]    = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status      <= '0;
      status[SLOT_LSB +: CW] <= CW'(DEPTH);
      irq         <= 1'b0;
      dma_in_req  <= 1'b0;
      dma_out_req <= 1'b0;
    end else if (!en) begin
      status      <= '0;
      irq         <= 1'b0;
      dma_in_req  <= 1'b0;
      dma_out_req <= 1'b0;
    end else begin
      status      <= stat_nxt;
      irq         <= (ie_data && (flg_nxt[F_LOW] || flg_nxt[F_HIGH] || flg_nxt[F_PCM]))
                  || (ie_err && (flg_nxt[F_UNDER] || flg_nxt[F_OVER]));
      dma_in_req  <= dma_in_en && flg_nxt[F_LOW];
      dma_out_req <= dma_out_en && flg_nxt[F_HIGH];
    end
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, icnt_q, ocnt_q, flg_q, i_over_unused, i_rise_unused,
                       o_under_unused, o_fall_unused};
endmodule

// File: rtl/codec_stat_chk.sv
module codec_stat_chk
  import codec_stat_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              in_pop,
  input logic              out_push,
  input logic              stat_rd,
  input logic              ie_data,
  input logic              ie_err,
  input logic [STAT_W-1:0] status,
  input logic              irq,
  input logic              dma_in_req,
  input logic              dma_out_req
);
  localparam int CW = $clog2(DEPTH + 1);

  // R1
  off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (status == '0 && !irq && !dma_in_req && !dma_out_req));

  // R2
  slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
    status[SLOT_LSB +: CW] <= CW'(DEPTH));

  // R5
  underrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (en && in_pop && status[SLOT_LSB +: CW] == CW'(DEPTH)) |=> (!en || status[F_UNDER]));

  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (en && out_push && status[SLOT_LSB + CW +: CW] == CW'(DEPTH)) |=> (!en || status[F_OVER]));

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status[F_UNDER] && !stat_rd) |=> (!en || status[F_UNDER]));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!ie_data && !ie_err) |=> !irq);

  // R10
  dma_in_align_chk: assert property (@(posedge clk) disable iff (rst)
    dma_in_req |-> status[F_LOW]);

  // R10
  dma_out_align_chk: assert property (@(posedge clk) disable iff (rst)
    dma_out_req |-> status[F_HIGH]);
endmodule

bind codec_stat_unit codec_stat_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .en(en), .in_pop(in_pop), .out_push(out_push),
  .stat_rd(stat_rd), .ie_data(ie_data), .ie_err(ie_err), .status(status),
  .irq(irq), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
);

// File: tb/codec_stat_unit_tb.sv
module codec_stat_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic in_push = 0, in_pop = 0, out_push = 0, out_pop = 0;
  logic pcm_out_full = 0, pcm_in_empty = 0, stat_rd = 0;
  logic ie_data = 1, ie_err = 1, dma_in_en = 1, dma_out_en = 1;
  logic [15:0] status;
  logic irq, dma_in_req, dma_out_req;
  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  codec_stat_unit #(.DEPTH(8), .THRESH(3)) u_dut (
    .clk(clk), .rst(rst), .en(en), .in_push(in_push), .in_pop(in_pop),
    .out_push(out_push), .out_pop(out_pop), .pcm_out_full(pcm_out_full),
    .pcm_in_empty(pcm_in_empty), .stat_rd(stat_rd), .ie_data(ie_data),
    .ie_err(ie_err), .dma_in_en(dma_in_en), .dma_out_en(dma_out_en),
    .status(status), .irq(irq), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
  );

  // entry: {ctl = in_push,in_pop,out_push,out_pop,rd ; flags ; free slots ; out words}
  localparam int NV = 21;
  localparam logic [17:0] TBL [NV] = '{
    {5'b01000, 5'b01000, 4'd8, 4'd0},
    {5'b00001, 5'b00000, 4'd8, 4'd0},
    {5'b10000, 5'b00000, 4'd7, 4'd0},
    {5'b10000, 5'b00000, 4'd6, 4'd0},
    {5'b10000, 5'b00000, 4'd5, 4'd0},
    {5'b10000, 5'b00000, 4'd4, 4'd0},
    {5'b01000, 5'b00001, 4'd5, 4'd0},
    {5'b01001, 5'b00000, 4'd6, 4'd0},
    {5'b11100, 5'b00000, 4'd6, 4'd1},
    {5'b00100, 5'b00000, 4'd6, 4'd2},
    {5'b00100, 5'b00000, 4'd6, 4'd3},
    {5'b00100, 5'b00000, 4'd6, 4'd4},
    {5'b00100, 5'b00010, 4'd6, 4'd5},
    {5'b00101, 5'b00000, 4'd6, 4'd6},
    {5'b00100, 5'b00000, 4'd6, 4'd7},
    {5'b00100, 5'b00000, 4'd6, 4'd8},
    {5'b00100, 5'b10000, 4'd6, 4'd8},
    {5'b01001, 5'b00000, 4'd7, 4'd8},
    {5'b00101, 5'b10000, 4'd7, 4'd8},
    {5'b00010, 5'b10000, 4'd7, 4'd7},
    {5'b00001, 5'b00000, 4'd7, 4'd7}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [4:0] ctl);
    {in_push, in_pop, out_push, out_pop, stat_rd} = ctl;
    @(posedge clk);
    @(negedge clk);
    {in_push, in_pop, out_push, out_pop, stat_rd} = '0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 reset status", 32'(status), 32'h0800);
    check("R1 reset irq", 32'(irq), 0);

    for (int i = 0; i < NV; i++) begin
      cyc(TBL[i][17:13]);
      // R2 R3 R4 R5 R6 R8 table step
      check($sformatf("R2 R3 R4 R5 R6 R8 step %0d status", i), 32'(status),
            32'({TBL[i][3:0], TBL[i][7:4], 3'b000, TBL[i][12:8]}));
      // R9 R10 with all enables on
      check($sformatf("R9 step %0d irq", i), 32'(irq), 32'(|TBL[i][12:8]));
      check($sformatf("R10 step %0d dma", i), 32'({dma_in_req, dma_out_req}),
            32'({TBL[i][8], TBL[i][9]}));
    end

    // R1 enable off clears everything
    en = 1'b0;
    pcm_in_empty = 1'b1;
    cyc(5'b10100);
    check("R1 disabled status", 32'(status), 0);
    check("R1 disabled irq", 32'(irq), 0);
    pcm_in_empty = 1'b0;
    en = 1'b1;
    cyc(5'b00000);
    check("R1 counts restart", 32'(status), 32'h0800);

    // R9 R10 separate enables
    ie_data = 1'b0; ie_err = 1'b1; dma_in_en = 1'b1; dma_out_en = 1'b0;
    for (int k = 0; k < 4; k++) cyc(5'b10000);
    cyc(5'b01000);
    check("R3 low flag", 32'(status[0]), 1);
    check("R9 data irq gated", 32'(irq), 0);
    check("R10 in dma", 32'(dma_in_req), 1);
    for (int k = 0; k < 3; k++) cyc(5'b01000);
    cyc(5'b01000);
    check("R5 underrun", 32'(status[3]), 1);
    check("R9 err irq", 32'(irq), 1);

    cyc(5'b00001);
    check("R8 read clears", 32'(status[4:0]), 0);
    check("R8 irq after clear", 32'(irq), 0);
    ie_err = 1'b0;
    for (int k = 0; k < 5; k++) cyc(5'b00100);
    check("R4 high flag", 32'(status[1]), 1);
    check("R10 out dma gated", 32'(dma_out_req), 0);
    check("R9 irq all off", 32'(irq), 0);

    // R7 PCM service with data interrupt
    cyc(5'b00001);
    ie_data = 1'b1;
    pcm_out_full = 1'b1;
    cyc(5'b00000);
    pcm_out_full = 1'b0;
    check("R7 pcm flag", 32'(status[2]), 1);
    check("R7 pcm irq", 32'(irq), 1);
    pcm_in_empty = 1'b1;
    cyc(5'b00001);
    check("R8 event beats read", 32'(status[2]), 1);
    pcm_in_empty = 1'b0;
    cyc(5'b00001);
    check("R8 pcm cleared", 32'(status[2]), 0);
    check("R9 irq drops", 32'(irq), 0);

    done = 1'b1;
    summary();
  end
endmodule